// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the interrupt acceptance stage that sits next to one processor core. It tracks 256 interrupt vectors in three 256-bit state vectors: pending requests, vectors in service, and the trigger mode of each vector. It raises a single request line to the core whenever a pending vector outranks the current processor priority. The processor priority is derived from a software task-priority value and from the highest vector already in service. Priority is compared by 4-bit class, which is the upper nibble of the vector number. Within the same class, a higher vector number wins.

The core takes an interrupt with a one-cycle acknowledge strobe. The vector it will receive is presented combinationally on `ack_vec_o` in the same cycle. When no vector can be delivered, that output carries the spurious vector, and the acknowledge leaves all state unchanged.

An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, the block emits a one-cycle broadcast pulse carrying the retired vector so that the interrupt sources can re-arm, unless software has selected directed end-of-interrupt. A level-deassert input withdraws a pending request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several vectors are pending and deliverable, `ack_vec_o` presents the highest-numbered pending vector.
- R2: `ppr_o` equals `tpr_o` when `tpr_o[7:4]` is greater than or equal to the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R3: A vector is deliverable only when the enable bit `svr_o[8]` is 1 and a request is pending. In addition, either `ppr_o` must be 0, or the best request's class must be strictly greater than `ppr_o[7:4]`.
- R4: When no vector is deliverable, `ack_vec_o` equals `svr_o[7:0]`, and an acknowledge in that state changes no state.
- R5: An acknowledge of a deliverable vector clears its request bit and sets its in-service bit. This is visible in `ppr_o` after the clock edge.
- R6: A request with `req_level_i`=1 marks the vector level-triggered. A later request of the same vector with `req_level_i`=0 marks it edge-triggered.
- R7: End-of-interrupt clears the highest in-service bit and does nothing when none is set. On the next edge it pulses `eoi_bcast_o` for one cycle with `eoi_bcast_vec_o` set to that vector. The pulse occurs only when the vector is level-triggered and `svr_o[12]` is 0.
- R8: `clr_valid_i` withdraws the pending request of `clr_vec_i`.
- R9: A write through `svr_we_i` keeps bits 8:0 and bit 12 of `svr_wdata_i`. `svr_o[11:9]` always reads 0.
- R10: After reset, all three 256-bit state vectors, `tpr_o` and `svr_o` are 0. This leaves the unit software-disabled with `irq_o` low.
- R11: When a request and a successful acknowledge of the same vector fall in one cycle, the acknowledge takes effect first and the request stays pending afterwards.
- R12: `irq_o` is registered. It reflects deliverability of the state one clock after that state is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_vec_i | input | 8 | Vector to set pending |
| req_level_i | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| clr_valid_i | input | 1 | Level-deassert strobe |
| clr_vec_i | input | 8 | Vector whose request is withdrawn |
| tpr_we_i | input | 1 | Task-priority write strobe |
| tpr_wdata_i | input | 8 | Task-priority write data |
| svr_we_i | input | 1 | Spurious/control register write strobe |
| svr_wdata_i | input | 16 | Spurious/control write data |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the core |
| ack_vec_o | output | 8 | Vector returned on acknowledge |
| tpr_o | output | 8 | Task-priority value |
| ppr_o | output | 8 | Processor-priority value |
| svr_o | output | 13 | Spurious vector [7:0], enable [8], directed EOI [12] |
| eoi_bcast_o | output | 1 | End-of-interrupt broadcast pulse |
| eoi_bcast_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
A wrong bit in the request set shows up on `ack_vec_o` in the same cycle. One cycle later it shows on `irq_o`. A wrong in-service bit shows up on `ppr_o` directly after the edge that formed it. It also appears as a wrong spurious-or-vector answer on the next acknowledge. A lost or wrong trigger-mode bit remains hidden until the matching end-of-interrupt. At that point it appears as a missing or extra `eoi_bcast_o` pulse one edge later. For this reason, the tests retire level vectors and edge vectors separately, and with directed end-of-interrupt both on and off.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned NUM_VEC = 256;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned VEC_W   = $clog2(NUM_VEC);
  localparam int unsigned CLS_W   = 4;
  localparam int unsigned SVR_W   = 13;
  localparam int unsigned SVR_EN  = 8;
  localparam int unsigned SVR_DIR = 12;
endpackage

// File: rtl/vec_prio_enc.sv
module vec_prio_enc #(
  parameter int unsigned N    = 256,
  parameter int unsigned WORD = 32
) (
  input  logic [N-1:0]         vec_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int unsigned NW = N / WORD;
  localparam int unsigned BW = $clog2(WORD);
  localparam int unsigned WW = $clog2(N) - BW;

  logic [NW-1:0] word_any;
  logic [BW-1:0] word_pos [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_comb begin
      word_pos[w] = '0;
      word_any[w] = |vec_i[w*WORD +: WORD];
      for (int b = 0; b < WORD; b++)
        if (vec_i[w*WORD+b]) word_pos[w] = BW'(b);
    end
  end

  // highest word wins, then highest bit within it
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int w = 0; w < NW; w++)
      if (word_any[w]) begin
        found_o = 1'b1;
        idx_o   = {WW'(w), word_pos[w]};
      end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
(
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             isr_found_i,
  input  logic [VEC_W-1:0] isr_idx_i,
  input  logic             irr_found_i,
  input  logic [VEC_W-1:0] irr_idx_i,
  input  logic             sw_en_i,
  input  logic [VEC_W-1:0] spur_vec_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             deliver_o,
  output logic [VEC_W-1:0] ack_vec_o
);
  localparam int unsigned LOW_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] isr_cls, tpr_cls, irr_cls;

  assign isr_cls = isr_found_i ? isr_idx_i[VEC_W-1 -: CLS_W] : '0;
  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_idx_i[VEC_W-1 -: CLS_W];

  assign ppr_o = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LOW_W{1'b0}}};

  assign deliver_o = sw_en_i && irr_found_i &&
                     ((ppr_o == '0) || (irr_cls > ppr_o[VEC_W-1 -: CLS_W]));

  assign ack_vec_o = deliver_o ? irr_idx_i : spur_vec_i;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vec_i,
  input  logic             req_level_i,
  input  logic             clr_valid_i,
  input  logic [VEC_W-1:0] clr_vec_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             svr_we_i,
  input  logic [15:0]      svr_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] ack_vec_o,
  output logic [VEC_W-1:0] tpr_o,
  output logic [VEC_W-1:0] ppr_o,
  output logic [SVR_W-1:0] svr_o,
  output logic             eoi_bcast_o,
  output logic [VEC_W-1:0] eoi_bcast_vec_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  logic [VEC_W-1:0]   tpr_q;
  logic [SVR_W-1:0]   svr_q;
  logic               irq_q, bcast_q;
  logic [VEC_W-1:0]   bcast_vec_q;

  logic               irr_found, isr_found, deliver, take, retire;
  logic [VEC_W-1:0]   irr_idx, isr_idx;

  vec_prio_enc #(.N(NUM_VEC), .WORD(WORD_W)) i_irr_enc (
    .vec_i(irr_q), .found_o(irr_found), .idx_o(irr_idx)
  );

  vec_prio_enc #(.N(NUM_VEC), .WORD(WORD_W)) i_isr_enc (
    .vec_i(isr_q), .found_o(isr_found), .idx_o(isr_idx)
  );

  irq_arbiter i_arb (
    .tpr_i      (tpr_q),
    .isr_found_i(isr_found),
    .isr_idx_i  (isr_idx),
    .irr_found_i(irr_found),
    .irr_idx_i  (irr_idx),
    .sw_en_i    (svr_q[SVR_EN]),
    .spur_vec_i (svr_q[VEC_W-1:0]),
    .ppr_o      (ppr_o),
    .deliver_o  (deliver),
    .ack_vec_o  (ack_vec_o)
  );

  assign take   = ack_i && deliver;
  assign retire = eoi_i && isr_found;

  // order: withdraw, acknowledge, then new request (request survives a same-cycle ack)
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (clr_valid_i) irr_d[clr_vec_i] = 1'b0;
    if (take) begin
      irr_d[irr_idx] = 1'b0;
      isr_d[irr_idx] = 1'b1;
    end
    if (retire) isr_d[isr_idx] = 1'b0;
    if (req_valid_i) begin
      irr_d[req_vec_i] = 1'b1;
      tmr_d[req_vec_i] = req_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q       <= '0;
      isr_q       <= '0;
      tmr_q       <= '0;
      tpr_q       <= '0;
      svr_q       <= '0;
      irq_q       <= 1'b0;
      bcast_q     <= 1'b0;
      bcast_vec_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
      irq_q <= deliver;
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (svr_we_i) svr_q <= {svr_wdata_i[SVR_DIR], 3'b000, svr_wdata_i[SVR_EN:0]};
      bcast_q <= retire && tmr_q[isr_idx] && !svr_q[SVR_DIR];
      if (retire) bcast_vec_q <= isr_idx;
    end
  end

  assign irq_o           = irq_q;
  assign tpr_o           = tpr_q;
  assign svr_o           = svr_q;
  assign eoi_bcast_o     = bcast_q;
  assign eoi_bcast_vec_o = bcast_vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eoi_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] ack_vec_o,
  input logic [VEC_W-1:0] tpr_o,
  input logic [VEC_W-1:0] ppr_o,
  input logic [SVR_W-1:0] svr_o,
  input logic             eoi_bcast_o
);
  AST_PPR_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ppr_o[7:4] >= tpr_o[7:4]); // R2

  AST_DISABLED_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !svr_o[SVR_EN] |-> ack_vec_o == svr_o[7:0]); // R3

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(svr_o[SVR_EN])); // R12

  AST_BCAST_AFTER_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> $past(eoi_i)); // R7

  AST_BCAST_NOT_DIRECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bcast_o |-> !$past(svr_o[SVR_DIR])); // R7

  AST_SVR_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svr_o[11:9] == 3'b000); // R9
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eoi_i(eoi_i), .irq_o(irq_o),
  .ack_vec_o(ack_vec_o), .tpr_o(tpr_o), .ppr_o(ppr_o), .svr_o(svr_o),
  .eoi_bcast_o(eoi_bcast_o)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_level_i = 0, clr_valid_i = 0;
  logic [7:0]  req_vec_i = 0, clr_vec_i = 0, tpr_wdata_i = 0;
  logic        tpr_we_i = 0, svr_we_i = 0, ack_i = 0, eoi_i = 0;
  logic [15:0] svr_wdata_i = 0;
  logic        irq_o, eoi_bcast_o;
  logic [7:0]  ack_vec_o, tpr_o, ppr_o, eoi_bcast_vec_o;
  logic [12:0] svr_o;
  int          n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  irq_prio_ctrl i_irq_prio_ctrl (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #2;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; #5; rst_ni = 1'b1; tick();
  endtask

  task automatic req(input logic [7:0] v, input logic lvl);
    req_valid_i = 1; req_vec_i = v; req_level_i = lvl; tick(); req_valid_i = 0;
  endtask

  task automatic ack(output logic [7:0] got);
    ack_i = 1; #1; got = ack_vec_o; tick(); ack_i = 0;
  endtask

  task automatic eoi();
    eoi_i = 1; tick(); eoi_i = 0;
  endtask

  task automatic wr_tpr(input logic [7:0] v);
    tpr_we_i = 1; tpr_wdata_i = v; tick(); tpr_we_i = 0;
  endtask

  task automatic wr_svr(input logic [15:0] v);
    svr_we_i = 1; svr_wdata_i = v; tick(); svr_we_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 irq", irq_o, 0);
    chk("R10 ppr", ppr_o, 0);
    chk("R10 tpr", tpr_o, 0);
    chk("R10 svr", svr_o, 0);
    chk("R10 bcast", eoi_bcast_o, 0);
  endtask

  task automatic t_enable();
    logic [7:0] g;
    do_reset();
    req(8'h40, 0); tick();
    chk("R3 disabled irq", irq_o, 0);
    chk("R4 disabled ack_vec", ack_vec_o, 8'h00);
    wr_svr(16'hF1FF);
    chk("R9 svr mask", svr_o, 13'h11FF);
    chk("R12 irq not yet", irq_o, 0);
    tick();
    chk("R12 irq after one cycle", irq_o, 1);
    ack(g);
    chk("R1 ack vec", g, 8'h40);
  endtask

  task automatic t_ack();
    logic [7:0] g;
    do_reset(); wr_svr(16'h01FF);
    req(8'h40, 0); req(8'h45, 0);
    chk("R1 highest", ack_vec_o, 8'h45);
    ack(g);
    chk("R5 ack got", g, 8'h45);
    chk("R5 ppr from isr", ppr_o, 8'h40);
    chk("R3 same class blocked", ack_vec_o, 8'hFF);
    ack(g);
    chk("R4 spurious got", g, 8'hFF);
    chk("R4 ppr unchanged", ppr_o, 8'h40);
    tick();
    chk("R4 irq low", irq_o, 0);
    eoi();
    chk("R4 request kept", ack_vec_o, 8'h40);
    chk("R2 empty isr ppr", ppr_o, 8'h00);
  endtask

  task automatic t_tpr();
    logic [7:0] g;
    do_reset(); wr_svr(16'h01FF);
    req(8'h80, 0); ack(g);
    chk("R2 ppr isr", ppr_o, 8'h80);
    wr_tpr(8'h95);
    chk("R2 ppr tpr", ppr_o, 8'h95);
    wr_tpr(8'h75);
    chk("R2 ppr isr above tpr", ppr_o, 8'h80);
    req(8'h90, 0);
    chk("R3 class above ppr", ack_vec_o, 8'h90);
    wr_tpr(8'h9A);
    chk("R3 blocked by tpr", ack_vec_o, 8'hFF);
    do_reset(); wr_svr(16'h01FF);
    req(8'h05, 0);
    chk("R3 ppr zero passes", ack_vec_o, 8'h05);
  endtask

  task automatic t_eoi();
    logic [7:0] g;
    do_reset(); wr_svr(16'h01FF);
    req(8'h30, 0); ack(g);
    req(8'h60, 1); ack(g);
    eoi();
    chk("R7 bcast level", eoi_bcast_o, 1);
    chk("R7 bcast vec", eoi_bcast_vec_o, 8'h60);
    chk("R7 ppr after eoi", ppr_o, 8'h30);
    eoi();
    chk("R7 one-cycle pulse / edge none", eoi_bcast_o, 0);
    chk("R7 isr empty", ppr_o, 0);
    eoi();
    chk("R7 empty eoi", eoi_bcast_o, 0);
    req(8'h60, 1); req(8'h60, 0); ack(g); eoi();
    chk("R6 edge clears level mark", eoi_bcast_o, 0);
    wr_svr(16'h11FF);
    req(8'h60, 1); ack(g); eoi();
    chk("R7 directed suppresses", eoi_bcast_o, 0);
  endtask

  task automatic t_clear();
    do_reset(); wr_svr(16'h01FF);
    req(8'h70, 1);
    chk("R8 pending", ack_vec_o, 8'h70);
    clr_valid_i = 1; clr_vec_i = 8'h70; tick(); clr_valid_i = 0;
    chk("R8 withdrawn", ack_vec_o, 8'hFF);
    tick();
    chk("R8 irq low", irq_o, 0);
  endtask

  task automatic t_collide();
    do_reset(); wr_svr(16'h01FF);
    req(8'h50, 0);
    req_valid_i = 1; req_vec_i = 8'h50; req_level_i = 0; ack_i = 1;
    tick(); req_valid_i = 0; ack_i = 0;
    chk("R11 in service", ppr_o, 8'h50);
    chk("R11 blocked while in service", ack_vec_o, 8'hFF);
    eoi();
    chk("R11 request kept", ack_vec_o, 8'h50);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_ack();
    t_tpr();
    t_eoi();
    t_clear();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule